// File: doc/BRIEF.md
# Indexed Auto-Increment Address Pointer Bank

This block holds the pointers a processor uses to walk several memory spaces. A single common index register acts as a shared offset: writing it reloads four address pointers in one clock, each with its own fixed base plus the written value. Five further index pointers and the four address pointers can also be written one by one. Each of them advances by one whenever an access to its own memory space is signalled, so the processor can stream through a space without rewriting the pointer.

The same processor address also drives a combinational decoder. It produces one-hot write enables for a bank of control registers and one-hot read enables for a bank of status registers. It also produces the select that tells the read capture path whether the current address lies in register space or in memory space. The memory arrays, the registers behind the enables and the bus handshake sit outside this block. All pointers are 12 bits wide and all arithmetic wraps modulo 4096.

Top module: `ptr_bank`

## Requirements
- R1: After reset the common index and all five index pointers read 0, and the four address pointers read their bases: 0x000 (scan-in), 0x400 (scan-out), 0x800 (expected), 0xC00 (mask).
- R2: A bus write to address 0x00 stores the data in the common index. On the same clock edge it loads each address pointer with its base plus the data.
- R3: The base-plus-offset sum wraps modulo 4096. For example, offset 0x500 loads the mask pointer with 0x100.
- R4: A pulse on `acc_strobe` increments exactly one pointer by one on the next edge. Space codes 0 to 4 select the index pointers in `idx_ptrs` slot order (vector, header/trailer, macro, sequencer, bridge-support). Codes 5 to 8 select address pointers 0 to 3.
- R5: Space codes 9 to 15 and cycles with `acc_strobe` low leave every pointer unchanged. The common index never increments.
- R6: A bus write to address 0x01 to 0x05 loads index slot (address − 1). A write to 0x06 to 0x09 loads address slot (address − 6). Such a write wins over an increment of the same pointer in the same cycle.
- R7: A common-index write wins over an increment of an address pointer in the same cycle.
- R8: An increment from 0xFFF gives 0x000.
- R9: While `bus_wr` is high at address 0x0A to 0x10, `ctrl_we` has only bit (address − 0x0A) set. Otherwise it is zero, including during reads.
- R10: While `bus_rd` is high at address 0x11 to 0x14, `stat_re` has only bit (address − 0x11) set. Otherwise it is zero, including during writes.
- R11: `rd_mem_sel` is 1 for addresses 0x18 to 0x1F (memory space) and 0 below 0x18 (register space).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Processor register/memory address |
| bus_wr | input | 1 | Write qualifier for the current address |
| bus_rd | input | 1 | Read qualifier for the current address |
| bus_wdata | input | 12 | Write data |
| acc_strobe | input | 1 | One access to a memory space this cycle |
| acc_space | input | 4 | Space code of the access |
| common_idx | output | 12 | Common index register |
| idx_ptrs | output | 60 | Five index pointers, slot 0 in the low bits |
| addr_ptrs | output | 48 | Four address pointers, slot 0 in the low bits |
| ctrl_we | output | 7 | One-hot control register write enables |
| stat_re | output | 4 | One-hot status register read enables |
| rd_mem_sel | output | 1 | 1 selects memory space for read capture |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high together. They also assume that every input is valid at each rising edge once reset is released. The bench drives only one of the two qualifiers at a time, and it changes inputs only on the falling edge. Decode checks raise the qualifier for a fraction of a half-period, so those probes never reach a rising edge and never disturb the pointers. Pointer values are sampled at the falling edge that follows the edge where they change.

// File: rtl/ptr_bank_pkg.sv
package ptr_bank_pkg;
    // Register-map layout of the bus address space
    localparam int NUM_IDX    = 5;
    localparam int NUM_ADR    = 4;
    localparam int NUM_CTRL   = 7;
    localparam int NUM_STAT   = 4;
    localparam int CIDX_SLOT  = 0;
    localparam int IDX_SLOT0  = CIDX_SLOT + 1;
    localparam int ADR_SLOT0  = IDX_SLOT0 + NUM_IDX;
    localparam int CTRL_SLOT0 = ADR_SLOT0 + NUM_ADR;
    localparam int STAT_SLOT0 = CTRL_SLOT0 + NUM_CTRL;
    localparam int NUM_SPACES = NUM_IDX + NUM_ADR;
    localparam int SPACE_W    = 4;

    typedef enum logic [SPACE_W-1:0] {
        SP_VECTOR   = 4'd0,
        SP_HDRTRL   = 4'd1,
        SP_MACRO    = 4'd2,
        SP_SEQ      = 4'd3,
        SP_BRIDGE   = 4'd4,
        SP_SCAN_IN  = 4'd5,
        SP_SCAN_OUT = 4'd6,
        SP_EXPECT   = 4'd7,
        SP_MASK     = 4'd8
    } space_e;
endpackage

// File: rtl/ptr_reg.sv
module ptr_reg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rst_val,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         inc,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= rst_val;
        else if (ld)  q <= ld_val;
        else if (inc) q <= q + W'(1);
    end

    // a load wins over an increment
    assert_load_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> q == $past(ld_val));
    // increment by one, wrapping at the top
    assert_step_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !ld) |=> q == $past(q) + W'(1));
    // idle pointer holds
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !ld) |=> $stable(q));
endmodule

// File: rtl/ptr_decode.sv
module ptr_decode
    import ptr_bank_pkg::*;
#(
    parameter int BUS_AW       = 5,
    parameter int MEM_WIN_BASE = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BUS_AW-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    output logic                cidx_we,
    output logic [NUM_IDX-1:0]  idx_we,
    output logic [NUM_ADR-1:0]  adr_we,
    output logic [NUM_CTRL-1:0] ctrl_we,
    output logic [NUM_STAT-1:0] stat_re,
    output logic                rd_mem_sel
);
    assign cidx_we    = bus_wr && (bus_addr == BUS_AW'(CIDX_SLOT));
    assign rd_mem_sel = (bus_addr >= BUS_AW'(MEM_WIN_BASE));

    for (genvar i = 0; i < NUM_IDX; i++) begin : g_idx
        assign idx_we[i] = bus_wr && (bus_addr == BUS_AW'(IDX_SLOT0 + i));
    end
    for (genvar j = 0; j < NUM_ADR; j++) begin : g_adr
        assign adr_we[j] = bus_wr && (bus_addr == BUS_AW'(ADR_SLOT0 + j));
    end
    for (genvar c = 0; c < NUM_CTRL; c++) begin : g_ctrl
        assign ctrl_we[c] = bus_wr && (bus_addr == BUS_AW'(CTRL_SLOT0 + c));
    end
    for (genvar s = 0; s < NUM_STAT; s++) begin : g_stat
        assign stat_re[s] = bus_rd && (bus_addr == BUS_AW'(STAT_SLOT0 + s));
    end

    assert_ctrl_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ctrl_we));
    assert_ctrl_wr_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|ctrl_we) |-> (bus_wr && !bus_rd));
    assert_stat_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stat_re));
    assert_stat_rd_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|stat_re) |-> (bus_rd && !bus_wr));
    assert_memsel_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_mem_sel |-> (ctrl_we == '0 && stat_re == '0 && !cidx_we));
    assert_one_ptr_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cidx_we, idx_we, adr_we}));
endmodule

// File: rtl/ptr_bank.sv
module ptr_bank
    import ptr_bank_pkg::*;
#(
    parameter int BUS_AW       = 5,
    parameter int PTR_W        = 12,
    parameter int MEM_WIN_BASE = 24,
    parameter logic [NUM_ADR*PTR_W-1:0] ADDR_BASES =
        {12'hC00, 12'h800, 12'h400, 12'h000}
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [BUS_AW-1:0]         bus_addr,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [PTR_W-1:0]          bus_wdata,
    input  logic                      acc_strobe,
    input  logic [SPACE_W-1:0]        acc_space,
    output logic [PTR_W-1:0]          common_idx,
    output logic [NUM_IDX*PTR_W-1:0]  idx_ptrs,
    output logic [NUM_ADR*PTR_W-1:0]  addr_ptrs,
    output logic [NUM_CTRL-1:0]       ctrl_we,
    output logic [NUM_STAT-1:0]       stat_re,
    output logic                      rd_mem_sel
);
    logic                cidx_we;
    logic [NUM_IDX-1:0]  idx_we;
    logic [NUM_ADR-1:0]  adr_we;

    ptr_decode #(.BUS_AW(BUS_AW), .MEM_WIN_BASE(MEM_WIN_BASE)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .cidx_we    (cidx_we),
        .idx_we     (idx_we),
        .adr_we     (adr_we),
        .ctrl_we    (ctrl_we),
        .stat_re    (stat_re),
        .rd_mem_sel (rd_mem_sel)
    );

    // common index: written only, never advanced
    ptr_reg #(.W(PTR_W)) u_cidx (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_val ('0),
        .ld      (cidx_we),
        .ld_val  (bus_wdata),
        .inc     (1'b0),
        .q       (common_idx)
    );

    for (genvar i = 0; i < NUM_IDX; i++) begin : g_idx
        logic bump;
        assign bump = acc_strobe && (acc_space == SPACE_W'(i));
        ptr_reg #(.W(PTR_W)) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .rst_val ('0),
            .ld      (idx_we[i]),
            .ld_val  (bus_wdata),
            .inc     (bump),
            .q       (idx_ptrs[i*PTR_W +: PTR_W])
        );
    end

    for (genvar j = 0; j < NUM_ADR; j++) begin : g_adr
        localparam logic [PTR_W-1:0] BASE = ADDR_BASES[j*PTR_W +: PTR_W];
        logic             bump;
        logic             load;
        logic [PTR_W-1:0] load_val;
        assign bump     = acc_strobe && (acc_space == SPACE_W'(NUM_IDX + j));
        assign load     = adr_we[j] || cidx_we;
        assign load_val = adr_we[j] ? bus_wdata : (BASE + bus_wdata);
        ptr_reg #(.W(PTR_W)) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .rst_val (BASE),
            .ld      (load),
            .ld_val  (load_val),
            .inc     (bump),
            .q       (addr_ptrs[j*PTR_W +: PTR_W])
        );

        // common-index write fans out as base plus offset (wraps)
        assert_fanout_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == BUS_AW'(CIDX_SLOT))
            |=> addr_ptrs[j*PTR_W +: PTR_W] == BASE + $past(bus_wdata));
    end

    assert_cidx_no_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == BUS_AW'(CIDX_SLOT)) |=> $stable(common_idx));
endmodule

// File: tb/ptr_bank_test.sv
module ptr_bank_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  bus_addr;
    logic        bus_wr, bus_rd;
    logic [11:0] bus_wdata;
    logic        acc_strobe;
    logic [3:0]  acc_space;
    logic [11:0] common_idx;
    logic [59:0] idx_ptrs;
    logic [47:0] addr_ptrs;
    logic [6:0]  ctrl_we;
    logic [3:0]  stat_re;
    logic        rd_mem_sel;

    int checks = 0;
    int failures = 0;
    logic [11:0] base [4] = '{12'h000, 12'h400, 12'h800, 12'hC00};

    always #4 clk = ~clk;

    ptr_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .acc_strobe(acc_strobe),
        .acc_space(acc_space), .common_idx(common_idx), .idx_ptrs(idx_ptrs),
        .addr_ptrs(addr_ptrs), .ctrl_we(ctrl_we), .stat_re(stat_re),
        .rd_mem_sel(rd_mem_sel)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] ix(int i); return idx_ptrs[i*12 +: 12]; endfunction
    function automatic logic [11:0] ad(int j); return addr_ptrs[j*12 +: 12]; endfunction

    // one clock with the given bus write and strobe, sampled at next falling edge
    task automatic cycle(logic wr, logic [4:0] a, logic [11:0] d, logic st, logic [3:0] sp);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; acc_strobe = st; acc_space = sp;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 5'h1F; acc_strobe = 1'b0;
    endtask

    task automatic test_reset();
        chk("R1 common", 32'(common_idx), 0);
        for (int i = 0; i < 5; i++) chk("R1 index", 32'(ix(i)), 0);
        for (int j = 0; j < 4; j++) chk("R1 address", 32'(ad(j)), 32'(base[j]));
    endtask

    task automatic test_common_write();
        cycle(1'b1, 5'h00, 12'h123, 1'b0, 4'd0);
        chk("R2 common", 32'(common_idx), 32'h123);
        for (int j = 0; j < 4; j++) chk("R2 fanout", 32'(ad(j)), 32'(base[j] + 12'h123));
    endtask

    task automatic test_wrap_sum();
        cycle(1'b1, 5'h00, 12'h500, 1'b0, 4'd0);
        chk("R3 mask wrap", 32'(ad(3)), 32'h100);
        chk("R3 expected", 32'(ad(2)), 32'hD00);
    endtask

    task automatic test_increment();
        logic [11:0] a0 [4];
        for (int j = 0; j < 4; j++) a0[j] = ad(j);
        for (int s = 0; s < 9; s++) cycle(1'b0, 5'h1F, 12'h0, 1'b1, 4'(s));
        for (int i = 0; i < 5; i++) chk("R4 index step", 32'(ix(i)), 1);
        for (int j = 0; j < 4; j++) chk("R4 address step", 32'(ad(j)), 32'(a0[j] + 12'd1));
    endtask

    task automatic test_ignored();
        logic [11:0] c0, i0 [5], a0 [4];
        c0 = common_idx;
        for (int i = 0; i < 5; i++) i0[i] = ix(i);
        for (int j = 0; j < 4; j++) a0[j] = ad(j);
        for (int s = 9; s < 16; s++) cycle(1'b0, 5'h1F, 12'h0, 1'b1, 4'(s));
        cycle(1'b0, 5'h1F, 12'h0, 1'b0, 4'd0);
        chk("R5 common", 32'(common_idx), 32'(c0));
        for (int i = 0; i < 5; i++) chk("R5 index", 32'(ix(i)), 32'(i0[i]));
        for (int j = 0; j < 4; j++) chk("R5 address", 32'(ad(j)), 32'(a0[j]));
    endtask

    task automatic test_direct_write();
        cycle(1'b1, 5'h03, 12'h0AB, 1'b1, 4'd2);
        chk("R6 index write beats inc", 32'(ix(2)), 32'h0AB);
        cycle(1'b1, 5'h07, 12'h321, 1'b1, 4'd6);
        chk("R6 address write beats inc", 32'(ad(1)), 32'h321);
        chk("R6 common untouched", 32'(common_idx), 32'h500);
    endtask

    task automatic test_common_vs_inc();
        cycle(1'b1, 5'h00, 12'h010, 1'b1, 4'd5);
        chk("R7 common beats inc", 32'(ad(0)), 32'h010);
        chk("R7 mask", 32'(ad(3)), 32'hC10);
    endtask

    task automatic test_wrap_inc();
        cycle(1'b1, 5'h01, 12'hFFF, 1'b0, 4'd0);
        cycle(1'b0, 5'h1F, 12'h0, 1'b1, 4'd0);
        chk("R8 index wrap", 32'(ix(0)), 0);
        cycle(1'b1, 5'h09, 12'hFFF, 1'b0, 4'd0);
        cycle(1'b0, 5'h1F, 12'h0, 1'b1, 4'd8);
        chk("R8 address wrap", 32'(ad(3)), 0);
    endtask

    // probes between edges; qualifier dropped before the next rising edge
    task automatic probe(logic wr, logic rd, logic [4:0] a);
        @(negedge clk);
        bus_addr = a; bus_wr = wr; bus_rd = rd;
        #1;
    endtask

    task automatic test_ctrl_decode();
        for (int c = 0; c < 7; c++) begin
            probe(1'b1, 1'b0, 5'(10 + c));
            chk("R9 ctrl one-hot", 32'(ctrl_we), 32'(7'd1 << c));
            chk("R10 no stat on write", 32'(stat_re), 0);
            bus_wr = 1'b0;
        end
        probe(1'b0, 1'b1, 5'h0C);
        chk("R9 no ctrl on read", 32'(ctrl_we), 0);
        bus_rd = 1'b0;
    endtask

    task automatic test_stat_decode();
        for (int s = 0; s < 4; s++) begin
            probe(1'b0, 1'b1, 5'(17 + s));
            chk("R10 stat one-hot", 32'(stat_re), 32'(4'd1 << s));
            chk("R9 no ctrl on read", 32'(ctrl_we), 0);
            bus_rd = 1'b0;
        end
        probe(1'b1, 1'b0, 5'h15);
        chk("R9 no ctrl past range", 32'(ctrl_we), 0);
        bus_wr = 1'b0;
    endtask

    task automatic test_mem_sel();
        probe(1'b0, 1'b0, 5'h17); chk("R11 register space", 32'(rd_mem_sel), 0);
        probe(1'b0, 1'b0, 5'h18); chk("R11 memory low", 32'(rd_mem_sel), 1);
        probe(1'b0, 1'b0, 5'h1F); chk("R11 memory high", 32'(rd_mem_sel), 1);
        probe(1'b0, 1'b0, 5'h00); chk("R11 address zero", 32'(rd_mem_sel), 0);
        bus_addr = 5'h1F;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_addr = 5'h1F; bus_wr = 1'b0; bus_rd = 1'b0;
        bus_wdata = '0; acc_strobe = 1'b0; acc_space = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_common_write();
        test_wrap_sum();
        test_increment();
        test_ignored();
        test_direct_write();
        test_common_vs_inc();
        test_wrap_inc();
        test_ctrl_decode();
        test_stat_decode();
        test_mem_sel();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule